// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers five interrupt sources and turns them into one vectored request for a CPU. The sources are external line 0, timer 0 overflow, external line 1, timer 1 overflow and the serial port. An enable register and a priority register sit on a small write bus. At every machine-cycle boundary, marked by a one-cycle `cycleTick` strobe, the block samples its inputs into flags. At the next boundary it polls those flags and raises a vector request with the handler address.

The CPU answers with `intAck` to take the vector and with `retiPulse` when a handler returns. The block keeps one in-service bit for each of the two priority levels, and these bits decide which requests may preempt a running handler.

Each external line is active low and can be sampled as a level or as a falling edge. On acknowledge, hardware clears edge-captured external flags and timer flags. A level-mode external request and the serial flag follow their inputs and are never cleared by the block.

Top module: `irqPrioCtl`

## Requirements
- R1: After reset both `enableQ` and `prioQ` read 0. Bits 6 and 5 of `enableQ` and bits 7 to 5 of `prioQ` always read 0, whatever value was written.
- R2: While enable bit 7 (the global enable) is 0, no vector request is raised, whatever the per-source enable bits hold.
- R3: Source i (0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial) can be requested only while enable bit i is 1.
- R4: Among requests at the same level, the lowest source index wins. The vector address is 8'h03 + 8*i.
- R5: A source whose priority bit i is 1 is high level. An eligible high-level source beats every low-level source, whatever their indices.
- R6: A flag is captured at one `cycleTick` and polled at the next one. `vecReq` rises only at a `cycleTick`, and never at the same tick that captures its flag.
- R7: `intAck` while `vecReq` is 1 drops `vecReq` on the next cycle and sets the in-service bit of that vector's level. Without `intAck` or `cycleTick`, `vecReq` and `vecAddr` hold.
- R8: While the low level is in service, only high-level sources are requested. While the high level is in service, nothing is requested.
- R9: `retiPulse` clears the high in-service bit if it is set, and otherwise clears the low one.
- R10: On acknowledge, the flags of timer sources and of edge-mode external sources are cleared. Level-mode external flags and the serial flag are not cleared.
- R11: With `extEdge[k]`=1, external k sets its flag once for each high-to-low transition seen between two ticks. A line that stays low does not request again after acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleTick | input | 1 | One-cycle strobe at each machine-cycle boundary |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects the enable register, 1 selects the priority register |
| regWdata | input | 8 | Write data |
| enableQ | output | 8 | Enable register contents |
| prioQ | output | 8 | Priority register contents |
| extLineN | input | 2 | External request lines, active low |
| extEdge | input | 2 | 1 selects falling-edge sampling for the matching line |
| timerOvf | input | 2 | Timer overflow pulses (index 0 is timer 0) |
| serialFlag | input | 1 | Serial receive-or-transmit flag, level |
| vecReq | output | 1 | Vector request to the CPU |
| vecAddr | output | 8 | Handler address of the pending vector |
| intAck | input | 1 | CPU takes the pending vector |
| retiPulse | input | 1 | Handler return |

## Verification
The bench checks that the request appears only at the second tick after a timer pulse. A controller with no flag stage would raise it one tick early. It goes through nested handling: a high-level timer preempts a low-level one, a low request stays blocked until two returns have popped both levels, and a controller that popped the wrong level on return would release the blocked request too soon. It also checks that an edge-captured line held low does not request a second time, while a level line and the serial flag do. A controller that cleared the wrong flags on acknowledge would either lose or repeat one of these requests.

// File: rtl/icPkg.sv
package icPkg;
  localparam int SRC_N = 5;
  localparam int IDX_W = $clog2(SRC_N);

  typedef struct packed {
    logic             loadVec;
    logic [IDX_W-1:0] pickIdx;
    logic             pickLvl;
    logic             takeAck;
    logic [SRC_N-1:0] ackClr;
    logic             popHi;
    logic             popLo;
  } ctrlStrobeT;
endpackage

// File: rtl/icDatapath.sv
module icDatapath
  import icPkg::*;
#(
  parameter logic [7:0] VEC_BASE = 8'h03,
  parameter logic [7:0] VEC_STEP = 8'h08
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleTick,
  input  logic             regWe,
  input  logic             regAddr,
  input  logic [7:0]       regWdata,
  input  logic [1:0]       extLineN,
  input  logic [1:0]       extEdge,
  input  logic [1:0]       timerOvf,
  input  logic             serialFlag,
  input  ctrlStrobeT       strobe,
  output logic [7:0]       enableQ,
  output logic [7:0]       prioQ,
  output logic [SRC_N-1:0] flagQ,
  output logic [1:0]       inSvc,
  output logic             vecReq,
  output logic [IDX_W-1:0] vecSrcQ,
  output logic [7:0]       vecAddr
);
  localparam logic [7:0] ENA_MASK = 8'h9F;
  localparam logic [7:0] PRI_MASK = 8'h1F;

  logic [1:0]       prevLine;
  logic [SRC_N-1:0] nextFlag;
  logic             vecLvlQ;

  // register bus
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      prioQ   <= '0;
    end else if (regWe) begin
      if (regAddr) prioQ   <= regWdata & PRI_MASK;
      else         enableQ <= regWdata & ENA_MASK;
    end
  end

  // flag capture: clear on acknowledge, set wins over clear
  always_comb begin
    nextFlag = flagQ & ~strobe.ackClr;
    if (cycleTick) begin
      for (int k = 0; k < 2; k++) begin
        if (extEdge[k])
          nextFlag[2*k] = nextFlag[2*k] | (prevLine[k] & ~extLineN[k]);
        else
          nextFlag[2*k] = ~extLineN[k];
        nextFlag[2*k+1] = nextFlag[2*k+1] | timerOvf[k];
      end
      nextFlag[SRC_N-1] = serialFlag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ    <= '0;
      prevLine <= 2'b11;
    end else begin
      flagQ <= nextFlag;
      if (cycleTick) prevLine <= extLineN;
    end
  end

  // in-service levels
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSvc <= '0;
    end else begin
      if (strobe.popHi) inSvc[1] <= 1'b0;
      if (strobe.popLo) inSvc[0] <= 1'b0;
      if (strobe.takeAck) inSvc[vecLvlQ] <= 1'b1;
    end
  end

  // pending vector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReq  <= 1'b0;
      vecSrcQ <= '0;
      vecLvlQ <= 1'b0;
    end else if (strobe.takeAck) begin
      vecReq <= 1'b0;
    end else if (cycleTick) begin
      vecReq  <= strobe.loadVec;
      vecSrcQ <= strobe.pickIdx;
      vecLvlQ <= strobe.pickLvl;
    end
  end

  assign vecAddr = VEC_BASE + 8'(VEC_STEP * 8'(vecSrcQ));
endmodule

// File: rtl/icControl.sv
module icControl
  import icPkg::*;
(
  input  logic [7:0]       enableQ,
  input  logic [7:0]       prioQ,
  input  logic [SRC_N-1:0] flagQ,
  input  logic [1:0]       inSvc,
  input  logic             vecReq,
  input  logic [IDX_W-1:0] vecSrcQ,
  input  logic [1:0]       extEdge,
  input  logic             intAck,
  input  logic             retiPulse,
  output ctrlStrobeT       strobe
);
  logic [SRC_N-1:0] elig, hiCand, loCand, clearable;

  function automatic logic [IDX_W-1:0] lowestSet(input logic [SRC_N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = SRC_N - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign elig      = flagQ & enableQ[SRC_N-1:0] & {SRC_N{enableQ[7]}};
  assign hiCand    = elig & prioQ[SRC_N-1:0] & {SRC_N{~inSvc[1]}};
  assign loCand    = elig & ~prioQ[SRC_N-1:0] & {SRC_N{~inSvc[1] & ~inSvc[0]}};
  assign clearable = {1'b0, 1'b1, extEdge[1], 1'b1, extEdge[0]};

  always_comb begin
    strobe = '0;
    if (|hiCand) begin
      strobe.loadVec = 1'b1;
      strobe.pickLvl = 1'b1;
      strobe.pickIdx = lowestSet(hiCand);
    end else if (|loCand) begin
      strobe.loadVec = 1'b1;
      strobe.pickIdx = lowestSet(loCand);
    end
    strobe.takeAck = intAck & vecReq;
    strobe.ackClr  = strobe.takeAck ? (clearable & (SRC_N'(1) << vecSrcQ)) : '0;
    strobe.popHi   = retiPulse & inSvc[1];
    strobe.popLo   = retiPulse & ~inSvc[1] & inSvc[0];
  end
endmodule

// File: rtl/irqPrioCtl.sv
module irqPrioCtl
  import icPkg::*;
#(
  parameter logic [7:0] VEC_BASE = 8'h03,
  parameter logic [7:0] VEC_STEP = 8'h08
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleTick,
  input  logic       regWe,
  input  logic       regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] enableQ,
  output logic [7:0] prioQ,
  input  logic [1:0] extLineN,
  input  logic [1:0] extEdge,
  input  logic [1:0] timerOvf,
  input  logic       serialFlag,
  output logic       vecReq,
  output logic [7:0] vecAddr,
  input  logic       intAck,
  input  logic       retiPulse
);
  ctrlStrobeT       strobe;
  logic [SRC_N-1:0] flagQ;
  logic [1:0]       inSvc;
  logic [IDX_W-1:0] vecSrcQ;

  icDatapath #(.VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .cycleTick(cycleTick),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .extLineN(extLineN), .extEdge(extEdge), .timerOvf(timerOvf),
    .serialFlag(serialFlag), .strobe(strobe),
    .enableQ(enableQ), .prioQ(prioQ), .flagQ(flagQ), .inSvc(inSvc),
    .vecReq(vecReq), .vecSrcQ(vecSrcQ), .vecAddr(vecAddr)
  );

  icControl u_ctl (
    .enableQ(enableQ), .prioQ(prioQ), .flagQ(flagQ), .inSvc(inSvc),
    .vecReq(vecReq), .vecSrcQ(vecSrcQ), .extEdge(extEdge),
    .intAck(intAck), .retiPulse(retiPulse), .strobe(strobe)
  );
endmodule

// File: rtl/icChecker.sv
module icChecker #(
  parameter logic [7:0] VEC_BASE = 8'h03,
  parameter logic [7:0] VEC_STEP = 8'h08
) (
  input logic       clk,
  input logic       rstN,
  input logic       cycleTick,
  input logic       intAck,
  input logic [7:0] enableQ,
  input logic [7:0] prioQ,
  input logic       vecReq,
  input logic [7:0] vecAddr
);
  localparam logic [7:0] VEC_LAST = VEC_BASE + 8'(VEC_STEP * 8'd4);

  // R1
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ[6:5] == 2'b00 && prioQ[7:5] == 3'b000));

  // R2
  global_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vecReq) |-> $past(enableQ[7]));

  // R4
  vec_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> (((vecAddr - VEC_BASE) % VEC_STEP) == 8'd0 && vecAddr <= VEC_LAST));

  // R6
  tick_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vecReq) |-> $past(cycleTick));

  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecReq && intAck) |=> !vecReq);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecReq && !intAck && !cycleTick) |=> (vecReq && $stable(vecAddr)));
endmodule

bind irqPrioCtl icChecker #(.VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_chk (
  .clk(clk), .rstN(rstN), .cycleTick(cycleTick), .intAck(intAck),
  .enableQ(enableQ), .prioQ(prioQ), .vecReq(vecReq), .vecAddr(vecAddr)
);

// File: tb/test_irqPrioCtl.sv
module test_irqPrioCtl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN, cycleTick, regWe, regAddr, serialFlag, intAck, retiPulse;
  logic [7:0] regWdata, enableQ, prioQ, vecAddr;
  logic [1:0] extLineN, extEdge, timerOvf;
  logic       vecReq;
  int         nRun = 0, nFail = 0;

  irqPrioCtl i_irqPrioCtl (
    .clk(clk), .rstN(rstN), .cycleTick(cycleTick), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .enableQ(enableQ), .prioQ(prioQ),
    .extLineN(extLineN), .extEdge(extEdge), .timerOvf(timerOvf),
    .serialFlag(serialFlag), .vecReq(vecReq), .vecAddr(vecAddr),
    .intAck(intAck), .retiPulse(retiPulse)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // row: enable, priority, extLineN, timerOvf, serial, expected req, expected vector
  localparam int ROWS = 10;
  localparam logic [29:0] TABLE [ROWS] = '{
    {8'h81, 8'h00, 2'b00, 2'b11, 1'b1, 1'b1, 8'h03},
    {8'h9F, 8'h00, 2'b00, 2'b11, 1'b1, 1'b1, 8'h03},
    {8'h9E, 8'h00, 2'b00, 2'b11, 1'b1, 1'b1, 8'h0B},
    {8'h9F, 8'h10, 2'b00, 2'b11, 1'b1, 1'b1, 8'h23},
    {8'h1F, 8'h00, 2'b00, 2'b11, 1'b1, 1'b0, 8'h00},
    {8'h9C, 8'h00, 2'b01, 2'b11, 1'b0, 1'b1, 8'h13},
    {8'h98, 8'h00, 2'b11, 2'b11, 1'b1, 1'b1, 8'h1B},
    {8'h9F, 8'h0C, 2'b00, 2'b11, 1'b1, 1'b1, 8'h13},
    {8'h90, 8'h00, 2'b11, 2'b00, 1'b1, 1'b1, 8'h23},
    {8'h9F, 8'h00, 2'b11, 2'b00, 1'b0, 1'b0, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cycleTick = 1'b0; regWe = 1'b0; regAddr = 1'b0; regWdata = '0;
    extLineN = 2'b11; extEdge = 2'b00; timerOvf = 2'b00; serialFlag = 1'b0;
    intAck = 1'b0; retiPulse = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tick();
    @(negedge clk) cycleTick = 1'b1;
    @(negedge clk) cycleTick = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk) begin regWe = 1'b1; regAddr = a; regWdata = d; end
    @(negedge clk) regWe = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk) intAck = 1'b1;
    @(negedge clk) intAck = 1'b0;
  endtask

  task automatic reti();
    @(negedge clk) retiPulse = 1'b1;
    @(negedge clk) retiPulse = 1'b0;
  endtask

  task automatic pulseTimer(input logic [1:0] which);
    timerOvf = which;
    tick();
    timerOvf = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 enable reset", 32'(enableQ), 32'h00);
    check("R1 priority reset", 32'(prioQ), 32'h00);
    check("R1 no request at reset", 32'(vecReq), 32'd0);
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'hFF);
    check("R1 enable reserved bits", 32'(enableQ), 32'h9F);
    check("R1 priority reserved bits", 32'(prioQ), 32'h1F);

    // table walk: R2 R3 R4 R5
    for (int r = 0; r < ROWS; r++) begin
      logic [29:0] row;
      row = TABLE[r];
      doReset();
      wr(1'b0, row[29:22]);
      wr(1'b1, row[21:14]);
      extLineN = row[13:12];
      serialFlag = row[9];
      pulseTimer(row[11:10]);
      tick();
      check($sformatf("R2 R3 R4 R5 row %0d req", r), 32'(vecReq), 32'(row[8]));
      if (row[8]) check($sformatf("R4 R5 row %0d vec", r), 32'(vecAddr), 32'(row[7:0]));
    end

    // R6 latency: captured at one tick, polled at the next
    doReset();
    wr(1'b0, 8'h82);
    pulseTimer(2'b01);
    check("R6 no request at capture tick", 32'(vecReq), 32'd0);
    repeat (3) @(negedge clk);
    check("R7 R6 no request between ticks", 32'(vecReq), 32'd0);
    tick();
    check("R6 request at next tick", 32'(vecReq), 32'd1);
    check("R6 vector timer0", 32'(vecAddr), 32'h0B);
    repeat (2) @(negedge clk);
    check("R7 request held", 32'(vecReq), 32'd1);

    // R8 R9 nesting: tf1 high, tf0 low
    wr(1'b0, 8'h8A);
    wr(1'b1, 8'h08);
    ack();
    check("R7 ack drops request", 32'(vecReq), 32'd0);
    pulseTimer(2'b10);
    tick();
    check("R8 high preempts low", 32'(vecReq), 32'd1);
    check("R8 preempt vector", 32'(vecAddr), 32'h1B);
    ack();
    pulseTimer(2'b01);
    tick();
    check("R8 high in service blocks all", 32'(vecReq), 32'd0);
    reti();
    tick();
    check("R9 first return pops high only", 32'(vecReq), 32'd0);
    reti();
    tick();
    check("R9 second return releases low", 32'(vecReq), 32'd1);
    check("R9 released vector", 32'(vecAddr), 32'h0B);
    ack();
    reti();
    tick(); tick();
    check("R10 timer flag cleared on ack", 32'(vecReq), 32'd0);

    // R11 R10 edge mode: held-low line requests once
    doReset();
    wr(1'b0, 8'h81);
    extEdge = 2'b01;
    extLineN = 2'b10;
    tick(); tick();
    check("R11 edge request", 32'(vecReq), 32'd1);
    check("R11 edge vector", 32'(vecAddr), 32'h03);
    ack(); reti();
    tick(); tick();
    check("R11 R10 held edge line no repeat", 32'(vecReq), 32'd0);

    // R10 level mode external flag persists
    doReset();
    wr(1'b0, 8'h84);
    extLineN = 2'b01;
    tick(); tick();
    check("R10 level request", 32'(vecAddr), 32'h13);
    ack(); reti();
    tick();
    check("R10 level flag not cleared", 32'(vecReq), 32'd1);

    // R10 serial flag persists
    doReset();
    wr(1'b0, 8'h90);
    serialFlag = 1'b1;
    tick(); tick();
    ack(); reti();
    tick();
    check("R10 serial flag not cleared", 32'(vecReq), 32'd1);
    check("R10 serial vector", 32'(vecAddr), 32'h23);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule